// File: doc/BRIEF.md
# TMDS Lane Symbol Encoder

This block turns one colour component of a transition-minimised differential video link into a stream of 10-bit line symbols. A link carries three such lanes (red, green, blue) plus a clock lane, so three copies of this encoder sit side by side, one per data lane.

On every pixel clock the encoder takes three inputs: a byte, a flag that marks active video, and a pair of control bits. During active video the byte passes through two steps. The first step chains the bits with XOR or XNOR to cut the number of line transitions. The second step may invert the eight payload bits, steered by a signed running tally of ones minus zeros, so that the line carries no DC content. Bit 8 of the symbol names the chaining method and bit 9 flags the inversion. During blanking the control bits pick one of four fixed symbols, and the tally is cleared.

Both steps are registered, so a symbol appears a fixed two clocks after its input.

Top module: `tmds_lane_enc`

## Requirements
- R1: The chaining step uses XNOR when the byte holds more than four ones, or exactly four ones with bit 0 clear. In every other case it uses XOR. Symbol bit 8 is 0 for XNOR and 1 for XOR.
- R2: In the chained word, bit 0 equals data bit 0. Each higher bit i is the XOR (or XNOR) of chained bit i-1 and data bit i. The chained word, taken after any inversion is undone, therefore decodes back to the original byte.
- R3: When the running tally is zero, or the chained eight bits hold four ones, symbol bit 9 is the inverse of bit 8. In that case the payload bits are inverted exactly when bit 8 is 0.
- R4: In all other active-video cases, the payload is inverted and bit 9 set to 1 when the tally and the chained word's ones surplus have the same sign. Otherwise the payload is sent unchanged with bit 9 at 0.
- R5: After each active symbol, the tally moves by that symbol's payload ones minus zeros. An inverted payload adds a correction of +2 times bit 8. A non-inverted payload with bit 8 at 0 subtracts 2. A cycle with the video flag low clears the tally to zero.
- R6: With the video flag low, control values 0, 1, 2 and 3 emit symbols 1101010100, 0010101011, 0101010100 and 1010101011, written from bit 9 down to bit 0.
- R7: A symbol appears on `sym_o` exactly two rising clock edges after its inputs are sampled.
- R8: While reset is held, and until new inputs reach the output, `sym_o` shows the control-0 symbol 1101010100 and the tally is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| de_i | input | 1 | High during active video |
| data_i | input | 8 | Colour byte for this lane |
| ctl_i | input | 2 | Control bits used during blanking |
| sym_o | output | 10 | Encoded line symbol |

## Verification
The bench targets four cases:
- Bytes with exactly four ones and each value of bit 0. If the tie-break in the method choice is swapped, these bytes come out with the wrong bit 8.
- Long runs of all-zero and all-one bytes, which drive the tally far from zero. Here a wrong sign comparison or a missing ±2 correction shows up as a wrong bit 9 a few symbols later.
- A blanking cycle placed in the middle of such a run. If the tally is not cleared, the next symbol takes the non-zero-tally branch.
- Transitions between control and data symbols. These catch a pipeline that is one stage short or long, and a control symbol table with swapped entries.

// File: rtl/tmds_pkg.sv
package tmds_pkg;
  localparam int DATA_W = 8;
  localparam int SYM_W  = DATA_W + 2;
  localparam int DISP_W = 6;
  localparam int CTL_W  = 2;
  localparam int CNT_W  = $clog2(DATA_W + 1);

  typedef logic [SYM_W-1:0]         sym_t;
  typedef logic [DATA_W:0]          qm_t;
  typedef logic signed [DISP_W-1:0] disp_t;

  localparam sym_t CTL_SYM [4] = '{10'b1101010100, 10'b0010101011,
                                   10'b0101010100, 10'b1010101011};

  function automatic logic [CNT_W-1:0] ones_of(input logic [DATA_W-1:0] v);
    logic [CNT_W-1:0] n;
    n = '0;
    for (int i = 0; i < DATA_W; i++) n = n + CNT_W'(v[i]);
    return n;
  endfunction

  // undo the chaining step; bit DATA_W=1 means XOR chain
  function automatic logic [DATA_W-1:0] qm_decode(input qm_t q);
    logic [DATA_W-1:0] d;
    d[0] = q[0];
    for (int i = 1; i < DATA_W; i++) d[i] = q[i] ^ q[i-1] ^ ~q[DATA_W];
    return d;
  endfunction

  function automatic logic [DATA_W-1:0] sym_decode(input sym_t s);
    qm_t q;
    q[DATA_W]        = s[DATA_W];
    q[DATA_W-1:0]    = s[DATA_W+1] ? ~s[DATA_W-1:0] : s[DATA_W-1:0];
    return qm_decode(q);
  endfunction
endpackage

// File: rtl/tmds_min_trans.sv
module tmds_min_trans
  import tmds_pkg::*;
(
  input  logic [DATA_W-1:0] data_i,
  output qm_t               qm_o
);
  logic [CNT_W-1:0]  n_ones;
  logic              use_xnor;
  logic [DATA_W-1:0] chain;

  assign n_ones   = ones_of(data_i);
  assign use_xnor = (n_ones > CNT_W'(DATA_W/2)) ||
                    ((n_ones == CNT_W'(DATA_W/2)) && !data_i[0]);

  assign chain[0] = data_i[0];
  for (genvar i = 1; i < DATA_W; i++) begin : g_chain
    assign chain[i] = use_xnor ? ~(chain[i-1] ^ data_i[i])
                               :  (chain[i-1] ^ data_i[i]);
  end

  assign qm_o = {~use_xnor, chain};
endmodule

// File: rtl/tmds_ctl_sym.sv
module tmds_ctl_sym
  import tmds_pkg::*;
(
  input  logic [CTL_W-1:0] ctl_i,
  output sym_t             sym_o
);
  always_comb begin
    unique case (ctl_i)
      2'd0:    sym_o = CTL_SYM[0];
      2'd1:    sym_o = CTL_SYM[1];
      2'd2:    sym_o = CTL_SYM[2];
      default: sym_o = CTL_SYM[3];
    endcase
  end
endmodule

// File: rtl/tmds_dc_bal.sv
module tmds_dc_bal
  import tmds_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic de_i,
  input  qm_t  qm_i,
  input  sym_t ctl_sym_i,
  output sym_t sym_o
);
  logic [CNT_W-1:0]  n1q;
  disp_t             surplus;
  disp_t             disp_q, disp_n;
  sym_t              sym_q, sym_n;
  logic              flag;
  logic [DATA_W-1:0] pay;

  assign flag    = qm_i[DATA_W];
  assign pay     = qm_i[DATA_W-1:0];
  assign n1q     = ones_of(pay);
  assign surplus = disp_t'(2 * int'(n1q) - DATA_W);

  always_comb begin
    if (!de_i) begin
      sym_n  = ctl_sym_i;
      disp_n = '0;
    end else if (disp_q == '0 || surplus == '0) begin
      sym_n  = {~flag, flag, flag ? pay : ~pay};
      disp_n = flag ? disp_q + surplus : disp_q - surplus;
    end else if (disp_q[DISP_W-1] == surplus[DISP_W-1]) begin
      sym_n  = {1'b1, flag, ~pay};
      disp_n = disp_q - surplus + (flag ? disp_t'(2) : disp_t'(0));
    end else begin
      sym_n  = {1'b0, flag, pay};
      disp_n = disp_q + surplus - (flag ? disp_t'(0) : disp_t'(2));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sym_q  <= CTL_SYM[0];
      disp_q <= '0;
    end else begin
      sym_q  <= sym_n;
      disp_q <= disp_n;
    end
  end

  assign sym_o = sym_q;

  AST_DISP_EVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disp_q[0] == 1'b0); // R5
  AST_DISP_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !de_i |=> disp_q == '0); // R5
  AST_FLAG_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    de_i |=> sym_q[DATA_W] == $past(qm_i[DATA_W])); // R1
  AST_ZERO_BRANCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (de_i && (disp_q == '0 || surplus == '0)) |=> sym_q[DATA_W+1] != sym_q[DATA_W]); // R3
endmodule

// File: rtl/tmds_lane_enc.sv
module tmds_lane_enc
  import tmds_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              de_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [CTL_W-1:0]  ctl_i,
  output logic [SYM_W-1:0]  sym_o
);
  qm_t  qm_c, qm_q;
  sym_t csym_c, csym_q;
  logic de_q;

  tmds_min_trans u_min (.data_i(data_i), .qm_o(qm_c));
  tmds_ctl_sym   u_ctl (.ctl_i(ctl_i), .sym_o(csym_c));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      qm_q   <= '0;
      csym_q <= CTL_SYM[0];
      de_q   <= 1'b0;
    end else begin
      qm_q   <= qm_c;
      csym_q <= csym_c;
      de_q   <= de_i;
    end
  end

  tmds_dc_bal u_bal (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .de_i     (de_q),
    .qm_i     (qm_q),
    .ctl_sym_i(csym_q),
    .sym_o    (sym_o)
  );

  // edges seen since reset, for history-safe checks
  logic [1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  AST_QM_ROUNDTRIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q != 2'd0 && $past(de_i)) |-> qm_decode(qm_q) == $past(data_i)); // R2
  AST_SYM_ROUNDTRIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q >= 2'd2 && $past(de_i, 2)) |-> sym_decode(sym_o) == $past(data_i, 2)); // R7
  AST_CTL_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q >= 2'd2 && !$past(de_i, 2)) |-> sym_o == CTL_SYM[$past(ctl_i, 2)]); // R6
endmodule

// File: tb/sim_tmds_lane_enc.sv
module sim_tmds_lane_enc;
  localparam int CLK_PERIOD = 10;
  localparam int N_RAND     = 4000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       de = 1'b0;
  logic [7:0] data = '0;
  logic [1:0] ctl = '0;
  logic [9:0] sym;

  int checks = 0;
  int errors = 0;
  int disp_m = 0;

  logic [9:0] e1, e2;
  logic       d1, d2;
  logic [7:0] b1, b2;
  string      t1, t2;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmds_lane_enc u0 (.clk_i(clk), .rst_ni(rst_n), .de_i(de), .data_i(data),
                    .ctl_i(ctl), .sym_o(sym));

  task automatic chk(input bit ok, input string tag, input logic [9:0] act,
                     input logic [9:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // R1/R2 reference chaining
  function automatic logic [8:0] ref_qm(input logic [7:0] d);
    logic [8:0] q;
    int n;
    bit x;
    n = $countones(d);
    x = (n > 4) || (n == 4 && d[0] == 1'b0);
    q[0] = d[0];
    for (int i = 1; i < 8; i++) q[i] = x ? ~(q[i-1] ^ d[i]) : (q[i-1] ^ d[i]);
    q[8] = ~x;
    return q;
  endfunction

  function automatic logic [9:0] ctl_ref(input logic [1:0] c);
    case (c)
      2'd0: return 10'b1101010100;
      2'd1: return 10'b0010101011;
      2'd2: return 10'b0101010100;
      default: return 10'b1010101011;
    endcase
  endfunction

  function automatic logic [7:0] undo(input logic [9:0] s);
    logic [7:0] p;
    logic [7:0] d;
    p = s[9] ? ~s[7:0] : s[7:0];
    d[0] = p[0];
    for (int i = 1; i < 8; i++) d[i] = s[8] ? (p[i] ^ p[i-1]) : ~(p[i] ^ p[i-1]);
    return d;
  endfunction

  task automatic step(input logic de_v, input logic [7:0] d_v, input logic [1:0] c_v,
                      input string ovr = "");
    logic [9:0] exp;
    logic [8:0] q;
    int s;
    string tag;
    @(negedge clk);
    chk(sym === e2, {"latency R7 rule ", t2}, sym, e2);
    if (d2) begin
      chk(sym[8] === ref_qm(b2)[8], "R1 method flag", sym, e2);
      chk(undo(sym) === b2, "R2 decode", {2'b00, undo(sym)}, {2'b00, b2});
    end
    e2 = e1; d2 = d1; b2 = b1; t2 = t1;
    de = de_v; data = d_v; ctl = c_v;
    if (!de_v) begin
      exp = ctl_ref(c_v); disp_m = 0; tag = "R6";
    end else begin
      q = ref_qm(d_v);
      s = 2 * $countones(q[7:0]) - 8;
      if (disp_m == 0 || s == 0) begin
        exp = {~q[8], q[8], q[8] ? q[7:0] : ~q[7:0]};
        disp_m = q[8] ? disp_m + s : disp_m - s;
        tag = "R3";
      end else if ((disp_m > 0) == (s > 0)) begin
        exp = {1'b1, q[8], ~q[7:0]};
        disp_m = disp_m - s + (q[8] ? 2 : 0);
        tag = "R4";
      end else begin
        exp = {1'b0, q[8], q[7:0]};
        disp_m = disp_m + s - (q[8] ? 0 : 2);
        tag = "R4";
      end
    end
    if (ovr != "") tag = ovr;
    e1 = exp; d1 = de_v; b1 = d_v; t1 = tag;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL R7 watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    e1 = 10'b1101010100; e2 = e1; d1 = 0; d2 = 0; b1 = 0; b2 = 0;
    t1 = "R8"; t2 = "R8";
    repeat (3) @(negedge clk);
    chk(sym === 10'b1101010100, "R8 reset symbol", sym, 10'b1101010100);
    rst_n = 1'b1;
    // R6 all four control codes
    for (int c = 0; c < 4; c++) step(1'b0, 8'h00, 2'(c));
    // R1 tie-break bytes, R7 control/data edges
    step(1'b1, 8'h0F, 0); step(1'b1, 8'hF0, 0); step(1'b1, 8'h00, 0);
    step(1'b1, 8'hFF, 0); step(1'b1, 8'h55, 0); step(1'b1, 8'hAA, 0);
    step(1'b0, 8'h00, 3);
    // R4/R5 push tally away from zero
    for (int i = 0; i < 12; i++) step(1'b1, 8'h00, 0);
    for (int i = 0; i < 12; i++) step(1'b1, 8'hFF, 0);
    for (int i = 0; i < 6; i++) step(1'b1, 8'h01, 0);
    step(1'b0, 8'h00, 1, "R5");   // tally cleared
    step(1'b1, 8'h01, 0, "R5");   // must take zero-tally branch
    step(1'b1, 8'h10, 0, "R5");
    for (int i = 0; i < N_RAND; i++) begin
      logic [7:0] v;
      v = 8'($urandom);
      if ($urandom_range(0, 3) == 0) v = ($urandom_range(0, 1) != 0) ? (v & 8'h03) : (v | 8'hFC);
      step($urandom_range(0, 19) != 0, v, 2'($urandom));
    end
    step(1'b0, 8'h00, 0); step(1'b0, 8'h00, 0); step(1'b0, 8'h00, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule